// File: doc/BRIEF.md
# Prioritized Round-Robin Channel Arbiter

This block chooses which of eight transfer channels may use a single shared transfer engine. Each channel has an enable bit, a mode bit that marks a memory-to-memory transfer, a service request line from its peripheral and a two-bit priority. A memory-to-memory channel asks for the engine as soon as it is enabled. A channel with a peripheral at either end asks only while its peripheral's service line is high.

The arbiter always grants the highest priority level that has a requester. Within that level it rotates among the requesters, and each level keeps its own pointer. A grant cannot be taken away by a later request. It ends only when the engine reports that the read phase and then the write phase have completed, or when it reports an error, which aborts the transfer. After each release the arbiter spends one idle cycle before it makes its next decision.

Top module: `dma_chan_arbiter`

## Requirements
- R1: A channel requests when it is enabled and either its mode bit (memory-to-memory) or its peripheral request is 1. A channel whose enable is 0 is never granted.
- R2: When requesters exist at different priority levels, the grant goes to one at the highest level. Priority value 3 is the highest level and 0 is the lowest.
- R3: Among requesters at the winning level, the grant goes to the first requesting channel index at or after that level's pointer, counting upward with wrap. The pointer then moves to the granted index plus one.
- R4: While a grant is held, `grant` stays stable whatever the request, priority or enable inputs do.
- R5: A held grant is released at the clock edge where `wr_done` is 1, provided `rd_done` has been seen during that grant, in an earlier cycle or in the same one. A `wr_done` that comes before any `rd_done` does not release the grant.
- R6: `xfer_err` set while a grant is held releases the grant at the next edge.
- R7: After a release, `grant_valid` is 0 for two cycles, an idle cycle followed by a decision cycle. The earliest next grant appears at the second edge after the release.
- R8: `grant` is one-hot whenever `grant_valid` is 1, and all zero otherwise.
- R9: After reset there is no grant and every level pointer is 0.
- R10: With no channel requesting, no grant is issued. A grant appears one edge after the decision cycle sees a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 8 | Per-channel enable |
| ch_m2m | input | 8 | Per-channel memory-to-memory mode bit |
| ch_periph_req | input | 8 | Per-channel peripheral service request |
| ch_prio | input | 16 | Two-bit priority per channel; channel i uses bits [2i+1:2i] |
| rd_done | input | 1 | Engine: read phase of the granted transfer finished |
| wr_done | input | 1 | Engine: write phase of the granted transfer finished |
| xfer_err | input | 1 | Engine: granted transfer aborted on error |
| grant | output | 8 | One-hot registered grant |
| grant_valid | output | 1 | A grant is held |

## Verification
A level pointer that is wrong, or one that is shared between levels, shows up as a wrong channel index at the very next grant edge of that level. The bench's queue of expected grant indices catches it at the moment `grant_valid` rises. A phase flag that is lost or set too early shows up as a grant that drops early or hangs. The bench checks this with a write-done sent ahead of any read-done. A control state that is wrong shows up as a missing or extra idle cycle, or as preemption by a later high-priority request. Both are checked cycle by cycle at the ports within two edges of the event.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_DECIDE = 2'd0,
    ST_HOLD   = 2'd1,
    ST_IDLE   = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dma_req_gen.sv
module dma_req_gen #(
  parameter int N_CH = 8
) (
  input  logic [N_CH-1:0] en,
  input  logic [N_CH-1:0] m2m,
  input  logic [N_CH-1:0] preq,
  output logic [N_CH-1:0] req
);
  genvar i;
  generate
    for (i = 0; i < N_CH; i++) begin : g_ch
      // memory-to-memory requests at once, otherwise peripheral-driven
      assign req[i] = en[i] & (m2m[i] | preq[i]);
    end
  endgenerate
endmodule

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
  parameter int N_CH  = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_CH-1:0]  req,
  input  logic [IDX_W-1:0] ptr,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < N_CH; k++) begin
      int j;
      j = (int'(ptr) + k) % N_CH;
      if (!any && req[j]) begin
        any = 1'b1;
        idx = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int PRIO_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_CH-1:0]        ch_en,
  input  logic [N_CH-1:0]        ch_m2m,
  input  logic [N_CH-1:0]        ch_periph_req,
  input  logic [N_CH*PRIO_W-1:0] ch_prio,
  input  logic                   rd_done,
  input  logic                   wr_done,
  input  logic                   xfer_err,
  output logic [N_CH-1:0]        grant,
  output logic                   grant_valid
);
  localparam int NLVL  = 1 << PRIO_W;
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int LVL_W = (PRIO_W > 0) ? PRIO_W : 1;

  logic [N_CH-1:0]  req;
  logic [N_CH-1:0]  lvl_req [NLVL];
  logic             lvl_any [NLVL];
  logic [IDX_W-1:0] lvl_idx [NLVL];
  logic [IDX_W-1:0] ptr_q   [NLVL];

  logic             win_any;
  logic [LVL_W-1:0] win_lvl;
  logic [IDX_W-1:0] win_idx;

  arb_state_e state_q;
  logic       rd_seen_q;
  logic       release_now;

  dma_req_gen #(.N_CH(N_CH)) u_req (
    .en   (ch_en),
    .m2m  (ch_m2m),
    .preq (ch_periph_req),
    .req  (req)
  );

  genvar l, c;
  generate
    for (l = 0; l < NLVL; l++) begin : g_lvl
      for (c = 0; c < N_CH; c++) begin : g_mask
        assign lvl_req[l][c] = req[c] && (ch_prio[c*PRIO_W +: PRIO_W] == PRIO_W'(l));
      end
      dma_rr_pick #(.N_CH(N_CH), .IDX_W(IDX_W)) u_pick (
        .req (lvl_req[l]),
        .ptr (ptr_q[l]),
        .any (lvl_any[l]),
        .idx (lvl_idx[l])
      );
    end
  endgenerate

  // highest populated level wins: later iterations override earlier ones
  always_comb begin
    win_any = 1'b0;
    win_lvl = '0;
    for (int v = 0; v < NLVL; v++) begin
      if (lvl_any[v]) begin
        win_any = 1'b1;
        win_lvl = LVL_W'(v);
      end
    end
    win_idx = lvl_idx[win_lvl];
  end

  assign release_now = xfer_err || (wr_done && (rd_seen_q || rd_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_DECIDE;
      grant       <= '0;
      grant_valid <= 1'b0;
      rd_seen_q   <= 1'b0;
      for (int v = 0; v < NLVL; v++) ptr_q[v] <= '0;
    end else begin
      case (state_q)
        ST_DECIDE: begin
          if (win_any) begin
            grant       <= N_CH'(1) << win_idx;
            grant_valid <= 1'b1;
            rd_seen_q   <= 1'b0;
            state_q     <= ST_HOLD;
            ptr_q[win_lvl] <= (int'(win_idx) == N_CH - 1) ? '0 : win_idx + 1'b1;
          end
        end
        ST_HOLD: begin
          if (release_now) begin
            grant       <= '0;
            grant_valid <= 1'b0;
            rd_seen_q   <= 1'b0;
            state_q     <= ST_IDLE;
          end else if (rd_done) begin
            rd_seen_q <= 1'b1;
          end
        end
        ST_IDLE: state_q <= ST_DECIDE;
        default: state_q <= ST_DECIDE;
      endcase
    end
  end
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int N_CH   = 8,
  parameter int PRIO_W = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_CH-1:0]        ch_en,
  input logic                   wr_done,
  input logic                   xfer_err,
  input logic [N_CH-1:0]        grant,
  input logic                   grant_valid
);
  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> ($onehot0(grant) && grant != '0));

  assert_empty_R8: assert property (@(posedge clk) disable iff (rst)
    !grant_valid |-> grant == '0);

  assert_enabled_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_valid) |-> (grant & $past(ch_en)) != '0);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !xfer_err && !wr_done) |=> (grant_valid && $stable(grant)));

  assert_abort_R6: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && xfer_err) |=> !grant_valid);

  assert_gap_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(grant_valid) |=> !grant_valid);
endmodule

bind dma_chan_arbiter dma_arb_checker #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ch_en       (ch_en),
  .wr_done     (wr_done),
  .xfer_err    (xfer_err),
  .grant       (grant),
  .grant_valid (grant_valid)
);

// File: tb/test_dma_chan_arbiter.sv
module test_dma_chan_arbiter;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] ch_en = '0, ch_m2m = '0, ch_periph_req = '0;
  logic [2*N-1:0] ch_prio = '0;
  logic rd_done = 1'b0, wr_done = 1'b0, xfer_err = 1'b0;
  logic [N-1:0] grant;
  logic         grant_valid;

  int checks = 0, errors = 0;
  int exp_q[$];
  bit prev_valid = 1'b0;

  always #4 clk = ~clk;

  dma_chan_arbiter #(.N_CH(N), .PRIO_W(2)) i_dma_chan_arbiter (
    .clk(clk), .rst(rst), .ch_en(ch_en), .ch_m2m(ch_m2m),
    .ch_periph_req(ch_periph_req), .ch_prio(ch_prio),
    .rd_done(rd_done), .wr_done(wr_done), .xfer_err(xfer_err),
    .grant(grant), .grant_valid(grant_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [N-1:0] g);
    for (int i = 0; i < N; i++) if (g[i]) return i;
    return -1;
  endfunction

  // monitor: pops the expected channel at each new grant (R2, R3, R8)
  always @(negedge clk) begin
    if (!rst) begin
      if (grant_valid)
        check($countones(grant) == 1, "R8 one-hot", $countones(grant), 1);
      else
        check(grant == '0, "R8 empty", int'(grant), 0);
      if (grant_valid && !prev_valid) begin
        if (exp_q.size() == 0)
          check(1'b0, "R10 unexpected grant", idx_of(grant), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(idx_of(grant) == e, "R2/R3 grant order", idx_of(grant), e);
        end
      end
      prev_valid = grant_valid;
    end
  end

  task automatic set_prio(input int ch, input int p);
    ch_prio[ch*2 +: 2] = 2'(p);
  endtask

  task automatic wait_grant();
    int n = 0;
    while (!grant_valid && n < 50) begin @(negedge clk); n++; end
  endtask

  task automatic finish_xact();
    rd_done = 1'b1; @(negedge clk);
    rd_done = 1'b0; wr_done = 1'b1; @(negedge clk);
    wr_done = 1'b0;
    check(!grant_valid, "R5 release after write", grant_valid, 0);
  endtask

  task automatic xact(input int ch, input bit drop);
    exp_q.push_back(ch);
    wait_grant();
    if (drop) ch_en[ch] = 1'b0;
    finish_xact();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!grant_valid && grant == '0, "R9 reset state", int'(grant), 0);

    // R1: disabled channels never granted
    ch_en = '0; ch_m2m = '1; ch_periph_req = '1;
    repeat (4) @(negedge clk);
    check(!grant_valid, "R1 disabled ignored", grant_valid, 0);

    // R10: enabled but nobody asking
    ch_en = '1; ch_m2m = '0; ch_periph_req = '0;
    repeat (4) @(negedge clk);
    check(!grant_valid, "R10 no request", grant_valid, 0);

    // R1: peripheral-driven request, then memory-to-memory
    ch_periph_req[3] = 1'b1;
    xact(3, 1'b1);
    ch_periph_req = '0;
    ch_m2m[5] = 1'b1;
    xact(5, 1'b1);
    ch_m2m = '0;

    // R2: levels 1, 2, 3 compete
    set_prio(1, 1); set_prio(4, 2); set_prio(6, 3);
    ch_m2m[1] = 1'b1; ch_m2m[4] = 1'b1; ch_m2m[6] = 1'b1;
    xact(6, 1'b1);
    xact(4, 1'b1);
    xact(1, 1'b1);
    ch_m2m = '0; ch_en = '1;

    // R3: level-2 pointer sits at 5 after channel 4
    set_prio(0, 2); set_prio(3, 2); set_prio(7, 2);
    ch_m2m[0] = 1'b1; ch_m2m[3] = 1'b1; ch_m2m[7] = 1'b1;
    xact(7, 1'b0);
    xact(0, 1'b0);
    xact(3, 1'b0);
    xact(7, 1'b0);
    ch_m2m = '0;
    repeat (3) @(negedge clk);

    // R4, R5, R7: no preemption, write-done before read-done ignored
    set_prio(2, 0); ch_m2m[2] = 1'b1;
    exp_q.push_back(2);
    wait_grant();
    ch_m2m[6] = 1'b1; set_prio(6, 3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(grant_valid && grant == 8'h04, "R4 held grant", int'(grant), 4);
    end
    wr_done = 1'b1; @(negedge clk);
    wr_done = 1'b0;
    check(grant_valid && grant == 8'h04, "R5 early write ignored", int'(grant), 4);
    @(negedge clk);
    check(grant_valid, "R5 still held", grant_valid, 1);
    exp_q.push_back(6);
    finish_xact();
    @(negedge clk);
    check(!grant_valid, "R7 decision cycle idle", grant_valid, 0);
    @(negedge clk);
    check(grant_valid && grant == 8'h40, "R7 grant at second edge", int'(grant), 64);

    // R6: abort on error
    xfer_err = 1'b1; @(negedge clk);
    xfer_err = 1'b0;
    check(!grant_valid, "R6 error release", grant_valid, 0);
    exp_q.push_back(6);
    @(negedge clk);
    check(!grant_valid, "R7 gap after error", grant_valid, 0);
    @(negedge clk);
    check(grant_valid && grant == 8'h40, "R6 regrant", int'(grant), 64);
    ch_m2m = '0;
    finish_xact();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all grants seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule